// File: doc/BRIEF.md
# Immediate-Amount Operand Shifter with Carry

This block is the operand shifter that sits in front of the ALU in a data-processing datapath. It is purely combinational. It takes a 32-bit register value, the current carry flag and an instruction word. From the instruction word it pulls out three fields: the index of the source register, a 2-bit shift kind and a 5-bit immediate shift amount. It returns three things: the shifted operand, the carry bit shifted out, and a strobe that says whether that carry should be written to the flag.

A zero immediate amount is not a no-op for every kind. For both right shifts it stands for a shift by the full word width. For rotate it stands for a one-place rotate through the carry flag. Only the left shift treats zero as a plain pass-through. A separate flag-setting input gates the carry strobe. The shifted result is produced whether or not flags are being set.

The register file, the ALU, the flag register and register-specified shift amounts all belong to neighbouring blocks.

Top module: `opshift_imm_unit`

## Requirements
- R1: `reg_index` equals instruction bits [3:0]. The shift kind is instruction bits [6:5], with 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. The amount is instruction bits [11:7].
- R2: Logical left by n in 1..31 gives `operand << n`, and the carry is operand bit 32-n.
- R3: Logical right by n in 1..31 fills with zeros from the top, and the carry is operand bit n-1.
- R4: Arithmetic right by n in 1..31 fills the top with copies of operand bit 31, and the carry is operand bit n-1.
- R5: Rotate right by n in 1..31 moves the low n bits to the top, and the carry is operand bit n-1.
- R6: Logical left with amount 0 passes the operand through unchanged. The carry output equals `carry_in` and `carry_we` stays low.
- R7: Logical right with amount 0 acts as a shift by 32. The result is all zeros and the carry is operand bit 31.
- R8: Arithmetic right with amount 0 acts as a shift by 32. Every result bit equals operand bit 31, and the carry is operand bit 31.
- R9: Rotate with amount 0 rotates one place through the carry. The result is `{carry_in, operand[31:1]}` and the carry is operand bit 0.
- R10: While `set_flags` is low, `carry_we` is low, and `result` and `carry_out` still follow R2 to R9.
- R11: While `set_flags` is high, `carry_we` is high for every kind and amount except logical left with amount 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word holding the register index, shift kind and amount fields |
| operand | input | 32 | Value of the source register |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | High when the instruction updates the flags |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Carry produced by the shift |
| carry_we | output | 1 | High when `carry_out` should be written to the carry flag |
| reg_index | output | 4 | Source register index taken from the instruction |

## Verification
The hardest behaviour to expose from the ports is the set of zero-amount forms. A shift by 32 is only visible when operand bit 31 differs from the bits below it. The one-place rotate through carry is only visible when `carry_in` differs from operand bit 31 and operand bit 0 differs from bit 1. The stimulus therefore sweeps amounts 0, 1 and 31 for every kind. It uses operands with opposite-valued end bits (`0x80000001`, `0x7FFFFFFE`) and a random one, each under both carry values, and then adds random instruction words with random flag-setting. Every item is predicted by a wide-arithmetic reference model and compared by a scoreboard.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;
endpackage

// File: rtl/opshift_field_decode.sv
module opshift_field_decode
   import opshift_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int IDX_W    = 4,
   parameter int IDX_LSB  = 0,
   parameter int KIND_LSB = 5,
   parameter int AMT_W    = 5,
   parameter int AMT_LSB  = 7
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [IDX_W-1:0]   reg_idx,
   output shift_kind_e        kind,
   output logic [AMT_W-1:0]   amt,
   output logic               amt_zero
);
   // bits outside the three fields are consumed by other decoders
   logic unused_instr;
   assign unused_instr = ^instr;

   assign reg_idx  = instr[IDX_LSB +: IDX_W];
   assign kind     = shift_kind_e'(instr[KIND_LSB +: 2]);
   assign amt      = instr[AMT_LSB +: AMT_W];
   assign amt_zero = (amt == '0);
endmodule

// File: rtl/opshift_datapath.sv
module opshift_datapath
   import opshift_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 5
) (
   input  logic [DATA_W-1:0] operand,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              amt_zero,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result
);
   localparam int MSB = DATA_W - 1;

   logic [AMT_W:0][DATA_W-1:0] lstage;
   logic [AMT_W:0][DATA_W-1:0] rstage;

   assign lstage[0] = operand;
   assign rstage[0] = operand;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic [STEP-1:0] rfill;

      always_comb begin
         case (kind)
            SK_ROR:  rfill = rstage[k][STEP-1:0];
            SK_ASR:  rfill = {STEP{operand[MSB]}};
            default: rfill = '0;
         endcase
      end

      assign lstage[k+1] = amt[k] ? {lstage[k][DATA_W-STEP-1:0], {STEP{1'b0}}}
                                  : lstage[k];
      assign rstage[k+1] = amt[k] ? {rfill, rstage[k][MSB:STEP]}
                                  : rstage[k];
   end

   always_comb begin
      if (amt_zero) begin
         case (kind)
            SK_LSL:  result = operand;
            SK_LSR:  result = '0;
            SK_ASR:  result = {DATA_W{operand[MSB]}};
            default: result = {carry_in, operand[MSB:1]};
         endcase
      end else if (kind == SK_LSL) begin
         result = lstage[AMT_W];
      end else begin
         result = rstage[AMT_W];
      end
   end
endmodule

// File: rtl/opshift_carry.sv
module opshift_carry
   import opshift_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 5
) (
   input  logic [DATA_W-1:0] operand,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              amt_zero,
   input  logic              carry_in,
   input  logic              set_flags,
   output logic              carry_out,
   output logic              carry_we
);
   localparam int MSB = DATA_W - 1;

   logic [AMT_W:0]   lsl_pos_w;
   logic [AMT_W-1:0] lsl_pos;
   logic [AMT_W-1:0] rsh_pos;
   logic             unused_pos;

   assign lsl_pos_w  = (AMT_W+1)'(DATA_W) - {1'b0, amt};
   assign lsl_pos    = lsl_pos_w[AMT_W-1:0];
   assign unused_pos = lsl_pos_w[AMT_W];
   assign rsh_pos    = amt - 1'b1;

   always_comb begin
      if (amt_zero) begin
         case (kind)
            SK_LSL:  carry_out = carry_in;
            SK_ROR:  carry_out = operand[0];
            default: carry_out = operand[MSB];
         endcase
      end else if (kind == SK_LSL) begin
         carry_out = operand[lsl_pos];
      end else begin
         carry_out = operand[rsh_pos];
      end
   end

   assign carry_we = set_flags & ~((kind == SK_LSL) & amt_zero);
endmodule

// File: rtl/opshift_imm_unit.sv
module opshift_imm_unit
   import opshift_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int INSTR_W  = 32,
   parameter int IDX_W    = 4,
   parameter int IDX_LSB  = 0,
   parameter int KIND_LSB = 5,
   parameter int AMT_LSB  = 7
) (
   input  logic [INSTR_W-1:0] instr_word,
   input  logic [DATA_W-1:0]  operand,
   input  logic               carry_in,
   input  logic               set_flags,
   output logic [DATA_W-1:0]  result,
   output logic               carry_out,
   output logic               carry_we,
   output logic [IDX_W-1:0]   reg_index
);
   localparam int AMT_W = $clog2(DATA_W);

   if (DATA_W < 4 || (1 << AMT_W) != DATA_W) begin : g_bad_width
      $error("opshift_imm_unit: DATA_W must be a power of two of at least 4");
   end
   if (IDX_LSB + IDX_W > INSTR_W || KIND_LSB + 2 > INSTR_W ||
       AMT_LSB + AMT_W > INSTR_W) begin : g_bad_field
      $error("opshift_imm_unit: a field lies outside the instruction word");
   end

   shift_kind_e      kind;
   logic [AMT_W-1:0] amt;
   logic             amt_zero;

   opshift_field_decode #(
      .INSTR_W (INSTR_W),
      .IDX_W   (IDX_W),
      .IDX_LSB (IDX_LSB),
      .KIND_LSB(KIND_LSB),
      .AMT_W   (AMT_W),
      .AMT_LSB (AMT_LSB)
   ) u_decode (
      .instr   (instr_word),
      .reg_idx (reg_index),
      .kind    (kind),
      .amt     (amt),
      .amt_zero(amt_zero)
   );

   opshift_datapath #(
      .DATA_W(DATA_W),
      .AMT_W (AMT_W)
   ) u_datapath (
      .operand (operand),
      .kind    (kind),
      .amt     (amt),
      .amt_zero(amt_zero),
      .carry_in(carry_in),
      .result  (result)
   );

   opshift_carry #(
      .DATA_W(DATA_W),
      .AMT_W (AMT_W)
   ) u_carry (
      .operand  (operand),
      .kind     (kind),
      .amt      (amt),
      .amt_zero (amt_zero),
      .carry_in (carry_in),
      .set_flags(set_flags),
      .carry_out(carry_out),
      .carry_we (carry_we)
   );
endmodule

// File: rtl/opshift_imm_unit_chk.sv
module opshift_imm_unit_chk #(
   parameter int DATA_W   = 32,
   parameter int INSTR_W  = 32,
   parameter int IDX_W    = 4,
   parameter int IDX_LSB  = 0,
   parameter int KIND_LSB = 5,
   parameter int AMT_LSB  = 7
) (
   input logic [INSTR_W-1:0] instr_word,
   input logic [DATA_W-1:0]  operand,
   input logic               carry_in,
   input logic               set_flags,
   input logic [DATA_W-1:0]  result,
   input logic               carry_out,
   input logic               carry_we,
   input logic [IDX_W-1:0]   reg_index
);
   localparam int AMT_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;

   logic [1:0]       k;
   logic [AMT_W-1:0] a;
   logic             unused_chk;

   assign k          = instr_word[KIND_LSB +: 2];
   assign a          = instr_word[AMT_LSB +: AMT_W];
   assign unused_chk = ^instr_word;

   always_comb begin
      // R1
      reg_field_chk: assert (reg_index == instr_word[IDX_LSB +: IDX_W])
         else $error("register index does not match instruction field");
      // R10
      flags_off_chk: assert (set_flags || !carry_we)
         else $error("carry strobe active with flag setting off");
      // R11
      flags_on_chk: assert (!set_flags || (k == 2'd0 && a == '0) || carry_we)
         else $error("carry strobe missing with flag setting on");
      // R6
      lsl_zero_chk: assert (!(k == 2'd0 && a == '0) ||
                            (result == operand && carry_out == carry_in && !carry_we))
         else $error("left shift by zero altered operand or flag");
      // R7
      lsr_zero_chk: assert (!(k == 2'd1 && a == '0) ||
                            (result == '0 && carry_out == operand[MSB]))
         else $error("right shift by full width wrong");
      // R8
      asr_zero_chk: assert (!(k == 2'd2 && a == '0) ||
                            (result == {DATA_W{operand[MSB]}} && carry_out == operand[MSB]))
         else $error("arithmetic shift by full width wrong");
      // R9
      rrx_chk: assert (!(k == 2'd3 && a == '0) ||
                       (result[MSB] == carry_in && result[MSB-1:0] == operand[MSB:1] &&
                        carry_out == operand[0]))
         else $error("rotate through carry wrong");
      // R3
      lsr_fill_chk: assert (!(k == 2'd1 && a != '0) || !result[MSB])
         else $error("logical right shift filled with a one");
      // R5
      ror_carry_chk: assert (!(k == 2'd3 && a != '0) || carry_out == result[MSB])
         else $error("rotate carry differs from top result bit");
   end
endmodule

bind opshift_imm_unit opshift_imm_unit_chk #(
   .DATA_W  (DATA_W),
   .INSTR_W (INSTR_W),
   .IDX_W   (IDX_W),
   .IDX_LSB (IDX_LSB),
   .KIND_LSB(KIND_LSB),
   .AMT_LSB (AMT_LSB)
) i_chk (.*);

// File: tb/test_opshift_imm_unit.sv
`timescale 1ns/1ps
module test_opshift_imm_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   always #4 clk = ~clk;

   logic [31:0] instr_word = '0;
   logic [31:0] operand    = '0;
   logic        carry_in   = 1'b0;
   logic        set_flags  = 1'b0;
   logic [31:0] result;
   logic        carry_out;
   logic        carry_we;
   logic [3:0]  reg_index;

   opshift_imm_unit i_opshift_imm_unit (
      .instr_word(instr_word),
      .operand   (operand),
      .carry_in  (carry_in),
      .set_flags (set_flags),
      .result    (result),
      .carry_out (carry_out),
      .carry_we  (carry_we),
      .reg_index (reg_index)
   );

   typedef struct {
      logic [31:0] res;
      logic        co;
      logic        we;
      logic [3:0]  idx;
      string       tag;
      string       wtag;
   } exp_t;

   exp_t sb_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // reference model in wide arithmetic
   function automatic exp_t model(logic [1:0] k, logic [4:0] a, logic [3:0] idx,
                                  logic [31:0] x, logic cin, logic sf);
      exp_t        e;
      int          n;
      logic [63:0] wide;
      n = (a == 0 && (k == 2'd1 || k == 2'd2)) ? 32 : int'(a);
      e.idx = idx;
      case (k)
         2'd0: begin
            if (a == 0) begin e.res = x; e.co = cin; e.tag = "R6"; end
            else begin
               wide = {32'b0, x} << n; e.res = wide[31:0]; e.co = wide[32]; e.tag = "R2";
            end
         end
         2'd1: begin
            wide = {x, 32'b0} >> n; e.res = wide[63:32]; e.co = wide[31];
            e.tag = (a == 0) ? "R7" : "R3";
         end
         2'd2: begin
            wide = $signed({x, 32'b0}) >>> n; e.res = wide[63:32]; e.co = wide[31];
            e.tag = (a == 0) ? "R8" : "R4";
         end
         default: begin
            if (a == 0) begin e.res = {cin, x[31:1]}; e.co = x[0]; e.tag = "R9"; end
            else begin
               wide = {x, x} >> n; e.res = wide[31:0]; e.co = e.res[31]; e.tag = "R5";
            end
         end
      endcase
      e.we   = sf && !(k == 2'd0 && a == 0);
      e.wtag = sf ? "R11" : "R10";
      return e;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: apply one item per cycle and push its prediction
   task automatic drive(logic [1:0] k, logic [4:0] a, logic [3:0] idx,
                        logic [31:0] x, logic cin, logic sf);
      logic [31:0] w;
      @(posedge clk);
      w = $urandom;
      w[3:0]  = idx;
      w[6:5]  = k;
      w[11:7] = a;
      instr_word = w;
      operand    = x;
      carry_in   = cin;
      set_flags  = sf;
      sb_q.push_back(model(k, a, idx, x, cin, sf));
   endtask

   // monitor: compare at the falling edge after the inputs settled
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk({e.tag, " result"}, result, e.res);
         chk({e.tag, " carry"}, 32'(carry_out), 32'(e.co));
         chk({e.wtag, " strobe"}, 32'(carry_we), 32'(e.we));
         chk("R1 index", 32'(reg_index), 32'(e.idx));
      end
   end

   initial begin
      logic [31:0] pats[3];
      int          amts[3];
      amts = '{0, 1, 31};
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle state after reset: all-zero inputs (R6, R10)
      drive(2'd0, 5'd0, 4'd0, 32'h0, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         for (int ai = 0; ai < 3; ai++) begin
            pats = '{32'h8000_0001, 32'h7FFF_FFFE, $urandom};
            for (int p = 0; p < 3; p++) begin
               for (int c = 0; c < 2; c++) begin
                  drive(2'(k), 5'(amts[ai]), 4'($urandom), pats[p], c[0], 1'b1);
               end
            end
         end
      end
      // R10: flags off, result still computed
      for (int k = 0; k < 4; k++) begin
         drive(2'(k), 5'd0, 4'hA, 32'hC000_0003, 1'b1, 1'b0);
         drive(2'(k), 5'd7, 4'h5, 32'h9234_5679, 1'b0, 1'b0);
      end
      // random sweep over R2..R11
      for (int i = 0; i < 400; i++) begin
         drive(2'($urandom), 5'($urandom), 4'($urandom), $urandom,
               1'($urandom), 1'($urandom));
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule